// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block tallies coins for a vending machine whose item costs twenty cents. Each cycle in which the coin strobe is high, a one-bit coin type is taken in: a low value stands for a five-cent coin and a high value for a ten-cent coin. The coin's value is added to a running credit, and the credit is held in a small register of five-cent steps.

The credit is shown on two decimal digits, each a 4-bit BCD code that goes straight to an external seven-segment decoder. A "paid" lamp comes on when the credit reaches the price. The credit never goes above twenty cents, so an overshoot such as fifteen plus ten still shows 20. Once the price is reached the controller stays locked: it still takes coin strobes but does nothing with them until the synchronous reset clears it.

The controller is split into two parts. A control part turns the coin strobe and coin type into step strobes. A datapath part holds the credit register, saturates it, and produces the digits and the lamp.

Top module: `coin_tally_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the credit becomes 0 after that edge: `tensDigit` = 0, `unitsDigit` = 0 and `paidLamp` = 0.
- R2: A rising edge with `coinValid` = 1 and `coinType` = 0, when the credit is below 20 cents, adds 5 cents. The new credit shows on the outputs right after that edge.
- R3: A rising edge with `coinValid` = 1 and `coinType` = 1, when the credit is below 20 cents, adds 10 cents. The new credit shows right after that edge.
- R4: A rising edge with `coinValid` = 0 leaves the credit unchanged, whatever the value of `coinType`.
- R5: `paidLamp` is 1 exactly when the shown credit is 20 cents, and 0 for every lower credit.
- R6: The credit never goes above 20 cents. A ten-cent coin taken at 15 cents gives exactly 20.
- R7: Once the credit is 20 cents, further coin strobes of either type leave the outputs unchanged until reset.
- R8: The outputs are BCD digits. `tensDigit` is 0, 1 or 2, `unitsDigit` is 0 or 5, and the credit equals 10 × tens + units.
- R9: When `rst` and `coinValid` are both high at the same edge, reset wins and the credit becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| coinValid | input | 1 | Strobe: one coin is presented at this edge |
| coinType | input | 1 | Coin kind when strobed: 0 = 5 cents, 1 = 10 cents |
| paidLamp | output | 1 | High when the credit has reached the price |
| tensDigit | output | 4 | BCD tens digit of the credit |
| unitsDigit | output | 4 | BCD units digit of the credit |

## Verification
The tests use several coin sequences.

- Four nickels in a row reach the price only through single steps.
- Two dimes reach it only through double steps.
- A nickel followed by two dimes forces the 15 + 10 overshoot, which separates a saturating adder from one that wraps or runs past 20.
- Coins of both types sent after the lock show whether the locked state really ignores input.
- Strobe-low cycles with a toggling coin type show that the coin type alone cannot move the credit.
- Reset raised together with a coin strobe shows which of the two takes priority.

// File: rtl/coin_tally_pkg.sv
package coin_tally_pkg;

  // Step strobes sent from control to datapath, one per accepted coin
  typedef struct packed {
    logic stepOne;   // add one unit (5 cents)
    logic stepTwo;   // add two units (10 cents)
  } step_t;

endpackage

// File: rtl/coin_tally_fsm.sv
module coin_tally_fsm
  import coin_tally_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  coinValid,
  input  logic  coinType,
  input  logic  full,
  output step_t steps
);

  logic accept;

  // A coin counts only when strobed and the price is not yet met
  always_comb begin
    accept        = coinValid && !full;
    steps.stepOne = accept && !coinType;
    steps.stepTwo = accept && coinType;
  end

  // R2 R3: at most one step kind per coin
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0({steps.stepOne, steps.stepTwo}));

  // R7: nothing is issued while locked
  a_r7_no_step_when_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !(steps.stepOne || steps.stepTwo));

endmodule

// File: rtl/coin_tally_dp.sv
module coin_tally_dp
  import coin_tally_pkg::*;
#(
  parameter int UNIT_CENTS  = 5,
  parameter int PRICE_CENTS = 20,
  parameter int DIGIT_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  step_t              steps,
  output logic               full,
  output logic               paidLamp,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic [DIGIT_W-1:0] unitsDigit
);

  localparam int LEVELS = PRICE_CENTS / UNIT_CENTS;
  localparam int LVL_W  = $clog2(LEVELS + 1);
  localparam logic [LVL_W-1:0] TOP    = LVL_W'(LEVELS);
  localparam logic [LVL_W:0]   TOP_EX = (LVL_W+1)'(LEVELS);

  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] levelNext;
  logic [LVL_W:0]   sumWide;
  int               centsNow;

  // Saturating step adder
  always_comb begin
    sumWide = {1'b0, level};
    if (steps.stepTwo)      sumWide = {1'b0, level} + (LVL_W+1)'(2);
    else if (steps.stepOne) sumWide = {1'b0, level} + (LVL_W+1)'(1);
    levelNext = (sumWide > TOP_EX) ? TOP : sumWide[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= levelNext;
  end

  // Display and lamp derived from the held level
  always_comb begin
    centsNow   = int'(level) * UNIT_CENTS;
    tensDigit  = DIGIT_W'(centsNow / 10);
    unitsDigit = DIGIT_W'(centsNow % 10);
    full       = (level == TOP);
    paidLamp   = full;
  end

  // R6: the level never exceeds the price
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= TOP);

  // R7: once full, stays full
  a_r7_locked: assert property (@(posedge clk) disable iff (rst)
    full |=> full);

  // R4: no step, no movement
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(steps.stepOne || steps.stepTwo) |=> $stable(level));

  // R8: units digit is 0 or 5
  a_r8_units_code: assert property (@(posedge clk) disable iff (rst)
    (unitsDigit == DIGIT_W'(0)) || (unitsDigit == DIGIT_W'(5)));

endmodule

// File: rtl/coin_tally_ctrl.sv
module coin_tally_ctrl
  import coin_tally_pkg::*;
#(
  parameter int UNIT_CENTS  = 5,
  parameter int PRICE_CENTS = 20,
  parameter int DIGIT_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               coinValid,
  input  logic               coinType,
  output logic               paidLamp,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic [DIGIT_W-1:0] unitsDigit
);

  localparam logic [DIGIT_W-1:0] PRICE_TENS  = DIGIT_W'(PRICE_CENTS / 10);
  localparam logic [DIGIT_W-1:0] PRICE_UNITS = DIGIT_W'(PRICE_CENTS % 10);

  step_t steps;
  logic  full;

  coin_tally_fsm uCtl (
    .clk       (clk),
    .rst       (rst),
    .coinValid (coinValid),
    .coinType  (coinType),
    .full      (full),
    .steps     (steps)
  );

  coin_tally_dp #(
    .UNIT_CENTS  (UNIT_CENTS),
    .PRICE_CENTS (PRICE_CENTS),
    .DIGIT_W     (DIGIT_W)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .steps      (steps),
    .full       (full),
    .paidLamp   (paidLamp),
    .tensDigit  (tensDigit),
    .unitsDigit (unitsDigit)
  );

  // R5: lamp implies the display shows the price
  a_r5_lamp_full: assert property (@(posedge clk) disable iff (rst)
    paidLamp |-> (tensDigit == PRICE_TENS && unitsDigit == PRICE_UNITS));

endmodule

// File: tb/sim_coin_tally_ctrl.sv
module sim_coin_tally_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coinValid = 1'b0;
  logic       coinType = 1'b0;
  logic       paidLamp;
  logic [3:0] tensDigit;
  logic [3:0] unitsDigit;

  int compared = 0;
  int mismatched = 0;
  int refCents = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  coin_tally_ctrl u0 (
    .clk        (clk),
    .rst        (rst),
    .coinValid  (coinValid),
    .coinType   (coinType),
    .paidLamp   (paidLamp),
    .tensDigit  (tensDigit),
    .unitsDigit (unitsDigit)
  );

  task automatic compare(input string tag);
    int expT = refCents / 10;
    int expU = refCents % 10;
    bit expL = (refCents >= 20);
    compared++;
    if (int'(tensDigit) != expT || int'(unitsDigit) != expU || paidLamp != expL) begin
      mismatched++;
      $display("FAIL %s: got tens=%0d units=%0d lamp=%0d, expected tens=%0d units=%0d lamp=%0d",
               tag, tensDigit, unitsDigit, paidLamp, expT, expU, expL);
    end
  endtask

  // One clock: drive after negedge, model at posedge, compare at next negedge
  task automatic cycle(input bit r, input bit v, input bit t, input string tag);
    rst = r; coinValid = v; coinType = t;
    @(posedge clk);
    if (r) refCents = 0;
    else if (v && refCents < 20) begin
      refCents = refCents + (t ? 10 : 5);
      if (refCents > 20) refCents = 20;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle(1, 0, 0, "R1 reset");
    cycle(1, 0, 1, "R1 reset held");
    // Nickels to the price
    for (int i = 0; i < 4; i++) cycle(0, 1, 0, "R2 R5 R8 nickel");
    cycle(0, 1, 0, "R7 nickel locked");
    cycle(0, 1, 1, "R7 dime locked");
    cycle(1, 0, 0, "R1 reset from full");
    // Dimes
    cycle(0, 1, 1, "R3 dime");
    cycle(0, 0, 1, "R4 idle type1");
    cycle(0, 0, 0, "R4 idle type0");
    cycle(0, 1, 1, "R3 R5 second dime");
    cycle(1, 0, 0, "R1 reset");
    // Overshoot 15 + 10
    cycle(0, 1, 0, "R2 nickel");
    cycle(0, 1, 1, "R3 dime to 15");
    cycle(0, 0, 1, "R4 idle at 15");
    cycle(0, 1, 1, "R6 overshoot saturates");
    for (int i = 0; i < 3; i++) cycle(0, 1, i % 2, "R7 locked stream");
    // Reset beats coin
    cycle(1, 1, 1, "R9 reset over dime");
    cycle(0, 1, 0, "R2 after reset");
    cycle(1, 1, 0, "R9 reset over nickel");
    // Mixed pattern with gaps
    cycle(0, 0, 1, "R4 idle at 0");
    cycle(0, 1, 0, "R2 R8 mixed");
    cycle(0, 1, 0, "R2 R8 mixed");
    cycle(0, 0, 0, "R4 idle at 10");
    cycle(0, 1, 0, "R2 R8 to 15");
    cycle(0, 1, 0, "R5 nickel to full");
    cycle(0, 0, 1, "R7 idle at full");
    rst = 0; coinValid = 0; coinType = 0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule